// File: doc/BRIEF.md
# Isochronous IN Frame Response Controller

This block decides, for each isochronous IN endpoint, how the device answers a host IN token. While a 1 ms frame runs, the block counts the bytes the CPU writes into each endpoint's IN FIFO. There is no count register that software reads or writes. A start-of-frame pulse ends the frame. At that pulse, each endpoint's running count is captured as the payload for the new frame, and the running count starts again from zero.

When an IN token arrives for an endpoint, the block reports one of three answers. If data was captured, the answer is a packet of that length. If no data was captured, the answer is a zero-length packet or no answer at all, as chosen by a configuration bit. Once captured data has been answered, a later token to the same endpoint in the same frame finds the endpoint empty. Each endpoint also has a sticky flag that records a write beyond a programmed maximum packet size. Packet serialisation and CRC are handled elsewhere.

Top module: `iso_in_resp_ctrl`

## Requirements
- R1: While reset is applied, and after it is released, `rsp_valid`, `rsp_zero`, `rsp_len` and `ovf_flag` are all zero. Before the first start-of-frame pulse, every endpoint is treated as empty.
- R2: An endpoint's payload is the number of `cpu_wr` cycles addressed to it (`cpu_wr_ep`) during the frame just ended. When a token arrives in the next frame and that payload is nonzero, the cycle after the token shows `rsp_valid`=1, `rsp_zero`=0 and `rsp_len` equal to the payload.
- R3: The per-endpoint write count is 10 bits wide and stops at 1023. Further writes leave it at 1023.
- R4: When a token finds its endpoint empty and `cfg_zlp_send`=1, the next cycle shows `rsp_valid`=1, `rsp_zero`=1 and `rsp_len`=0. `cfg_zlp_send` holds bit 7 of the endpoint pairing configuration register.
- R5: When a token finds its endpoint empty and `cfg_zlp_send`=0, `rsp_valid`, `rsp_zero` and `rsp_len` stay 0 in the next cycle (no answer).
- R6: After a token has been answered with captured data, a second token to the same endpoint before the next start-of-frame pulse is treated as empty.
- R7: Counts, captured payloads and overflow flags are kept separately per endpoint. Writes and tokens for one endpoint never change another endpoint's answer.
- R8: A write sets that endpoint's `ovf_flag` bit (bit index = endpoint number) in the next cycle when the bytes already counted in the frame are greater than or equal to `cfg_max_pkt`. The write is still counted. The flag then stays set until reset.
- R9: A write in the same cycle as a start-of-frame pulse counts toward the new frame, not the frame being captured. A token in that cycle is answered from the state before the pulse.
- R10: `rsp_valid` is high only in the cycle that follows an `in_tok` cycle, for exactly one cycle. With no response, `rsp_zero` and `rsp_len` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_wr | input | 1 | CPU writes one byte into an IN FIFO this cycle |
| cpu_wr_ep | input | 2 | Endpoint targeted by `cpu_wr` |
| sof_pulse | input | 1 | Start-of-frame pulse, one cycle |
| in_tok | input | 1 | Host IN token received, one cycle |
| in_tok_ep | input | 2 | Endpoint addressed by `in_tok` |
| cfg_zlp_send | input | 1 | 1: answer an empty endpoint with a zero-length packet; 0: stay silent |
| cfg_max_pkt | input | 10 | Maximum packet size used for overflow detection |
| rsp_valid | output | 1 | One-cycle strobe: send a data packet |
| rsp_zero | output | 1 | The packet being sent has zero length |
| rsp_len | output | 10 | Payload length of the packet being sent |
| ovf_flag | output | 4 | Sticky per-endpoint overflow flags |

## Verification
The response outputs are due exactly one clock edge after the token cycle. The overflow flags are due one edge after the write that crosses the limit. The bench drives each stimulus at a falling edge and lets one rising edge pass. At the following falling edge it compares the response outputs and the flags with values its model computed from the state before that edge. Every cycle is checked this way, so a strobe that arrives early, arrives late or lasts too long is caught in the cycle where it appears. Coincident start-of-frame, write and token cycles are handled by the model's ordering, which follows R9.

// File: rtl/iso_in_pkg.sv
package iso_in_pkg;
  // Width of the per-endpoint byte counter and payload length.
  localparam int ISO_LEN_W = 10;
  // Default number of isochronous IN endpoints handled.
  localparam int ISO_NUM_EP = 4;

  // Index width for a given number of endpoints (at least one bit).
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/iso_rst_sync.sv
module iso_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  // Assertion is asynchronous; release is synchronised by two flops.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/iso_ep_tracker.sv
module iso_ep_tracker #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic             sof,
  input  logic             tok_hit,
  input  logic [CNT_W-1:0] max_pkt,
  output logic [CNT_W-1:0] cur_len,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] load_q, load_d;
  logic [CNT_W-1:0] tx_q, tx_d;
  logic             pend_q, pend_d;
  logic             ovf_q, ovf_d;
  logic [CNT_W-1:0] base;
  logic             load_en, tx_en, pend_en, ovf_en;

  // Next-state logic
  always_comb begin
    base   = sof ? '0 : load_q;
    load_d = load_q;
    tx_d   = tx_q;
    pend_d = pend_q;
    ovf_d  = ovf_q;
    if (sof) begin
      tx_d   = load_q;
      pend_d = 1'b1;
      load_d = '0;
    end else if (tok_hit) begin
      pend_d = 1'b0;
    end
    if (wr_hit) begin
      if (base >= max_pkt) ovf_d = 1'b1;
      if (base != CNT_MAX) load_d = base + 1'b1;
    end
  end

  assign load_en = sof | wr_hit;
  assign tx_en   = sof;
  assign pend_en = sof | tok_hit;
  assign ovf_en  = wr_hit;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      tx_q   <= '0;
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (load_en) load_q <= load_d;
      if (tx_en)   tx_q   <= tx_d;
      if (pend_en) pend_q <= pend_d;
      if (ovf_en)  ovf_q  <= ovf_d;
    end
  end

  assign cur_len = pend_q ? tx_q : '0;
  assign ovf     = ovf_q;

  // R3
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q == CNT_MAX && !sof) |=> (load_q == CNT_MAX));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R6
  served_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_hit && !sof) |=> (cur_len == '0));

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (cur_len == $past(load_q)));
endmodule

// File: rtl/iso_rsp_unit.sv
module iso_rsp_unit #(
  parameter int NUM_EP = 4,
  parameter int CNT_W  = 10,
  parameter int EP_W   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_tok,
  input  logic [EP_W-1:0]             in_tok_ep,
  input  logic                        zlp_en,
  input  logic [NUM_EP-1:0][CNT_W-1:0] ep_len,
  output logic                        rsp_valid,
  output logic                        rsp_zero,
  output logic [CNT_W-1:0]            rsp_len
);
  localparam int SLOTS = 1 << EP_W;

  logic [SLOTS-1:0][CNT_W-1:0] len_pad;
  logic [CNT_W-1:0] sel_len;
  logic             sel_empty;
  logic             valid_d, zero_d;
  logic [CNT_W-1:0] len_d;

  // Pad to a full power-of-two table; absent endpoints read as empty.
  for (genvar s = 0; s < SLOTS; s++) begin : g_pad
    if (s < NUM_EP) begin : g_real
      assign len_pad[s] = ep_len[s];
    end else begin : g_none
      assign len_pad[s] = '0;
    end
  end

  assign sel_len   = len_pad[in_tok_ep];
  assign sel_empty = (sel_len == '0);

  always_comb begin
    valid_d = in_tok & (!sel_empty | zlp_en);
    zero_d  = in_tok & sel_empty & zlp_en;
    len_d   = in_tok ? sel_len : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_zero  <= 1'b0;
      rsp_len   <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_zero  <= zero_d;
      rsp_len   <= len_d;
    end
  end

  // R10
  strobe_only_after_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_tok |=> !rsp_valid);

  // R4
  zlp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_zero) |-> (rsp_len == '0));

  // R5
  silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tok && sel_empty && !zlp_en) |=> (!rsp_valid && rsp_len == '0));

  // R2
  data_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tok && !sel_empty) |=> (rsp_valid && !rsp_zero && rsp_len == $past(sel_len)));
endmodule

// File: rtl/iso_in_resp_ctrl.sv
module iso_in_resp_ctrl
  import iso_in_pkg::*;
#(
  parameter int  NUM_EP = ISO_NUM_EP,
  parameter int  CNT_W  = ISO_LEN_W,
  localparam int EP_W   = idx_bits(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [EP_W-1:0]   cpu_wr_ep,
  input  logic              sof_pulse,
  input  logic              in_tok,
  input  logic [EP_W-1:0]   in_tok_ep,
  input  logic              cfg_zlp_send,
  input  logic [CNT_W-1:0]  cfg_max_pkt,
  output logic              rsp_valid,
  output logic              rsp_zero,
  output logic [CNT_W-1:0]  rsp_len,
  output logic [NUM_EP-1:0] ovf_flag
);
  logic                         rst_n_s;
  logic [NUM_EP-1:0]            wr_hit;
  logic [NUM_EP-1:0]            tok_hit;
  logic [NUM_EP-1:0][CNT_W-1:0] ep_len;

  iso_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_s)
  );

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    assign wr_hit[e]  = cpu_wr & (cpu_wr_ep == EP_W'(e));
    assign tok_hit[e] = in_tok & (in_tok_ep == EP_W'(e));

    iso_ep_tracker #(.CNT_W(CNT_W)) u_trk (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .wr_hit  (wr_hit[e]),
      .sof     (sof_pulse),
      .tok_hit (tok_hit[e]),
      .max_pkt (cfg_max_pkt),
      .cur_len (ep_len[e]),
      .ovf     (ovf_flag[e])
    );
  end

  iso_rsp_unit #(.NUM_EP(NUM_EP), .CNT_W(CNT_W), .EP_W(EP_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .in_tok    (in_tok),
    .in_tok_ep (in_tok_ep),
    .zlp_en    (cfg_zlp_send),
    .ep_len    (ep_len),
    .rsp_valid (rsp_valid),
    .rsp_zero  (rsp_zero),
    .rsp_len   (rsp_len)
  );

  // R7
  one_hot_wr_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(wr_hit));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (ovf_flag == '0 && !rsp_valid));
endmodule

// File: tb/iso_in_resp_ctrl_tb.sv
module iso_in_resp_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_wr, sof_pulse, in_tok, cfg_zlp_send;
  logic [1:0] cpu_wr_ep, in_tok_ep;
  logic [9:0] cfg_max_pkt;
  logic       rsp_valid, rsp_zero;
  logic [9:0] rsp_len;
  logic [3:0] ovf_flag;

  int tests = 0;
  int fails = 0;
  int ld[4], tx[4], pend[4], ovf[4];
  bit zlp;
  int maxp;

  always #2 clk = ~clk;

  iso_in_resp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wr_ep(cpu_wr_ep),
    .sof_pulse(sof_pulse), .in_tok(in_tok), .in_tok_ep(in_tok_ep),
    .cfg_zlp_send(cfg_zlp_send), .cfg_max_pkt(cfg_max_pkt),
    .rsp_valid(rsp_valid), .rsp_zero(rsp_zero), .rsp_len(rsp_len),
    .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int ovf_vec();
    int v = 0;
    for (int e = 0; e < 4; e++) if (ovf[e] != 0) v |= (1 << e);
    return v;
  endfunction

  // Called at a falling edge: drive one cycle, update model, check after the next rising edge.
  task automatic step(input bit wr, input int wep, input bit sof,
                      input bit tok, input int tep, input string tag);
    int eff, el, ebase;
    bit ev, ez, hit;
    string t;
    eff = (pend[tep] != 0) ? tx[tep] : 0;
    ev = 0; ez = 0; el = 0;
    if (tok) begin
      if (eff > 0) begin ev = 1; el = eff; end
      else if (zlp) begin ev = 1; ez = 1; end
    end
    t = tag;
    if (t == "") t = !tok ? "R10" : (eff > 0 ? "R2" : (zlp ? "R4" : "R5"));
    cpu_wr = wr; cpu_wr_ep = 2'(wep); sof_pulse = sof;
    in_tok = tok; in_tok_ep = 2'(tep);
    cfg_zlp_send = zlp; cfg_max_pkt = 10'(maxp);
    for (int e = 0; e < 4; e++) begin
      hit = wr && (wep == e);
      ebase = sof ? 0 : ld[e];
      if (sof) begin tx[e] = ld[e]; pend[e] = 1; ld[e] = 0; end
      else if (tok && tep == e) pend[e] = 0;
      if (hit) begin
        if (ebase >= maxp) ovf[e] = 1;
        if (ebase < 1023) ld[e] = ebase + 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(t, {rsp_valid, rsp_zero, rsp_len}, {ev, ez, 10'(el)});
    chk("R8", int'(ovf_flag), ovf_vec());
    cpu_wr = 0; sof_pulse = 0; in_tok = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int e = 0; e < 4; e++) begin ld[e] = 0; tx[e] = 0; pend[e] = 0; ovf[e] = 0; end
    zlp = 0; maxp = 64;
    rst_n = 0; cpu_wr = 0; cpu_wr_ep = 0; sof_pulse = 0; in_tok = 0; in_tok_ep = 0;
    cfg_zlp_send = 0; cfg_max_pkt = 10'd64;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1", {rsp_valid, rsp_zero, rsp_len, ovf_flag}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", {rsp_valid, rsp_zero, rsp_len, ovf_flag}, 0);
    // R1: empty before first frame, silent then zero-length
    step(0, 0, 0, 1, 0, "R1");
    zlp = 1;
    step(0, 0, 0, 1, 0, "R1");
    // R2/R7: load two endpoints
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, "");
    for (int i = 0; i < 3; i++) step(1, 2, 0, 0, 0, "");
    step(0, 0, 1, 0, 0, "");
    step(0, 0, 0, 1, 1, "R2");
    step(0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 1, 2, "R7");
    step(0, 0, 0, 1, 1, "R6");
    zlp = 0;
    step(0, 0, 0, 1, 1, "R6");
    step(0, 0, 0, 1, 0, "R5");
    // R9: write coincident with frame start counts in new frame
    step(1, 3, 0, 0, 0, "");
    step(1, 3, 1, 1, 3, "R9");
    step(0, 0, 0, 1, 3, "R9");
    step(0, 0, 1, 0, 0, "");
    step(0, 0, 0, 1, 3, "R9");
    // R3/R8: saturation and overflow on endpoint 3
    for (int i = 0; i < 1030; i++) step(1, 3, 0, 0, 0, "");
    step(0, 0, 1, 0, 0, "");
    step(0, 0, 0, 1, 3, "R3");
    chk("R8", int'(ovf_flag[3]), 1);
    // Random phase
    maxp = 1 + int'($urandom % 40);
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 16) == 0) zlp = ~zlp;
      step(($urandom % 2) == 0, int'($urandom % 4), ($urandom % 40) == 0,
           ($urandom % 8) == 0, int'($urandom % 4), "");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule